// File: doc/BRIEF.md
# Sequential-Probe Pseudo-Associative Cache Set

This block is one cache set made of several ways. Each way is looked up as if it were a small direct-mapped cache of its own. The ways are searched one at a time in a fixed order, one way per clock, starting at the first way. There are no recency bits. Recency is kept by where a line sits: the most recently used line is always in the first way, and the line in the last way is the next one to be replaced.

A hit in a later way moves that line to the front. Each line that was ahead of it moves back by one position. A miss asks the next level for the block through a refill handshake. The refilled line goes in at the front, every line moves back by one position, and the line that falls off the last way leaves through an eviction port.

The set handles one request at a time. It takes no new request until the reordering step has finished.

Top module: `seqprobe_set`

## Requirements
- R1: After reset every way is invalid. `req_ready` is 1 and `rsp_valid`, `refill_req_valid` and `evict_valid` are 0. The first access to any address is therefore a miss.
- R2: Ways are examined one per clock, starting at way 1. A hit in way j reports `rsp_probes` = j, and `rsp_valid` is high in the cycle after the j-th rising edge that follows the accepting edge.
- R3: On a miss all WAYS ways are examined first. `refill_req_valid` then rises after the WAYS-th rising edge following acceptance, with `refill_req_addr` equal to the request address. Both stay unchanged until `refill_valid` is seen.
- R4: A hit in way j > 1 moves that line to way 1. Ways 1 to j-1 each move down by one position, and ways after j keep their lines.
- R5: A hit in way 1 leaves the order of all ways unchanged.
- R6: On a miss the refilled line goes into way 1. Every other line moves down by one position, and the line that was in the last way leaves the set.
- R7: When a miss pushes a valid line out of the last way, `evict_valid` is 1 in the response cycle and only then. In that cycle `evict_addr`, `evict_data` and `evict_dirty` carry that line. When the last way is invalid, no eviction is signalled.
- R8: A write (`req_wr` = 1) replaces the whole line data with `req_wdata` and marks the line dirty. On a write miss the line is refilled first and then overwritten. `rsp_data` reports the written data.
- R9: A read returns the stored line data on a hit and the refill data on a miss, on `rsp_data`.
- R10: `req_ready` is 0 from the accepting edge through the response cycle. `rsp_valid` is a one-cycle pulse, and the set accepts the next request in the cycle after the response.
- R11: Valid lines always form a leading run of ways, and no two valid ways ever hold the same address. An access repeated straight after a miss hits in way 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Set is idle and accepts a request |
| req_addr | input | ADDR_W | Block address of the request |
| req_wr | input | 1 | 1 = write whole line, 0 = read |
| req_wdata | input | DATA_W | Line data for a write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_probes | output | $clog2(WAYS+1) | Number of ways examined |
| rsp_data | output | DATA_W | Line data after the access |
| refill_req_valid | output | 1 | Refill wanted from next level |
| refill_req_addr | output | ADDR_W | Address to refill |
| refill_valid | input | 1 | Refill data present |
| refill_data | input | DATA_W | Refilled line data |
| evict_valid | output | 1 | A valid line leaves the set |
| evict_addr | output | ADDR_W | Address of the leaving line |
| evict_data | output | DATA_W | Data of the leaving line |
| evict_dirty | output | 1 | Leaving line was written |

## Verification
The hardest case to reach is a dirty line that was written, pushed back position by position through every way and then evicted while the refill answer is delayed. In that case the eviction port has to report data that was stored several reorderings earlier. A directed sequence builds this case once by hand. A long random run then draws from seven addresses over four ways, with about a third of the accesses being writes and refill delays of zero to three cycles. That way hits occur at every depth and dirty lines regularly reach the last way. The bench predicts the position of every line with its own model and checks the probe count, the timing, the data and the eviction of each access.

// File: rtl/seqprobe_pkg.sv
package seqprobe_pkg;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_PROBE,
        PS_REFILL_WAIT,
        PS_SHIFT
    } probe_state_e;

    // Width of a way index, at least one bit.
    function automatic int unsigned way_index_width(int unsigned ways);
        return (ways > 2) ? $clog2(ways) : 1;
    endfunction

    // A way moves down during a reorder when it lies in 1..depth.
    function automatic logic moves_down(int unsigned pos, int unsigned depth);
        return (pos != 0) && (pos <= depth);
    endfunction

endpackage

// File: rtl/seqprobe_lines.sv
module seqprobe_lines
    import seqprobe_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             shift_en,
    input  logic [IDX_W-1:0]                 depth,
    input  logic [2+TAG_W+DATA_W-1:0]        new_line,
    output logic [WAYS*(2+TAG_W+DATA_W)-1:0] lines_flat
);

    localparam int LINE_W = 2 + TAG_W + DATA_W;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t cur [WAYS];
    line_t nxt [WAYS];
    line_t head_in;

    assign head_in = line_t'(new_line);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        if (w == 0) begin : g_head
            assign nxt[w] = shift_en ? head_in : cur[w];
        end else begin : g_tail
            assign nxt[w] = (shift_en && moves_down(32'(w), 32'(depth))) ? cur[w-1] : cur[w];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cur[w] <= '0;
            end else begin
                cur[w] <= nxt[w];
            end
        end

        assign lines_flat[w*LINE_W +: LINE_W] = cur[w];

        if (w > 0) begin : g_lead
            AST_VALID_LEADING_RUN: assert property (@(posedge clk) disable iff (rst)
                cur[w].valid |-> cur[w-1].valid)
                else $error("valid way follows an invalid way"); // R11
        end

        for (genvar v = w + 1; v < WAYS; v++) begin : g_pair
            AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
                !(cur[w].valid && cur[v].valid && (cur[w].tag == cur[v].tag)))
                else $error("same address held in two ways"); // R11
        end
    end

endmodule

// File: rtl/seqprobe_match.sv
module seqprobe_match
    import seqprobe_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic [WAYS*(2+TAG_W+DATA_W)-1:0] lines_flat,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [TAG_W-1:0]                 tag,
    output logic                             hit,
    output logic [2+TAG_W+DATA_W-1:0]        sel_line
);

    localparam int LINE_W = 2 + TAG_W + DATA_W;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t ways_arr [WAYS];
    line_t sel;

    for (genvar w = 0; w < WAYS; w++) begin : g_unpack
        assign ways_arr[w] = line_t'(lines_flat[w*LINE_W +: LINE_W]);
    end

    assign sel      = ways_arr[idx];
    assign sel_line = sel;
    assign hit      = sel.valid && (sel.tag == tag);

endmodule

// File: rtl/seqprobe_fsm.sv
module seqprobe_fsm
    import seqprobe_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int IDX_W   = 2,
    parameter int PROBE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_fire,
    input  logic               probe_hit,
    input  logic               refill_valid,
    output probe_state_e       state,
    output logic [IDX_W-1:0]   idx,
    output logic               was_hit,
    output logic [PROBE_W-1:0] probes
);

    localparam logic [IDX_W-1:0] LAST_WAY = IDX_W'(WAYS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_IDLE;
            idx     <= '0;
            was_hit <= 1'b0;
        end else begin
            case (state)
                PS_IDLE: begin
                    if (req_fire) begin
                        state <= PS_PROBE;
                        idx   <= '0;
                    end
                end
                PS_PROBE: begin
                    if (probe_hit) begin
                        was_hit <= 1'b1;
                        state   <= PS_SHIFT;
                    end else if (idx == LAST_WAY) begin
                        was_hit <= 1'b0;
                        state   <= PS_REFILL_WAIT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PS_REFILL_WAIT: begin
                    if (refill_valid) begin
                        state <= PS_SHIFT;
                    end
                end
                PS_SHIFT: state <= PS_IDLE;
                default:  state <= PS_IDLE;
            endcase
        end
    end

    assign probes = PROBE_W'(idx) + PROBE_W'(1);

    AST_PROBE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == PS_PROBE) |-> (idx <= LAST_WAY))
        else $error("probe index beyond last way"); // R2

    AST_REFILL_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (state == PS_REFILL_WAIT) |-> (!was_hit && idx == LAST_WAY))
        else $error("refill wait entered before every way was probed"); // R3

    AST_START_AT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state == PS_IDLE && req_fire) |=> (state == PS_PROBE && idx == '0))
        else $error("probe did not start at way 1"); // R2

endmodule

// File: rtl/seqprobe_set.sv
module seqprobe_set
    import seqprobe_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int PROBE_W = $clog2(WAYS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_wr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [PROBE_W-1:0] rsp_probes,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               refill_req_valid,
    output logic [ADDR_W-1:0]  refill_req_addr,
    input  logic               refill_valid,
    input  logic [DATA_W-1:0]  refill_data,
    output logic               evict_valid,
    output logic [ADDR_W-1:0]  evict_addr,
    output logic [DATA_W-1:0]  evict_data,
    output logic               evict_dirty
);

    localparam int IDX_W  = way_index_width(WAYS);
    localparam int LINE_W = 2 + ADDR_W + DATA_W;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [ADDR_W-1:0] tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        logic [ADDR_W-1:0] tag;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    probe_state_e             state;
    logic [IDX_W-1:0]         idx;
    logic                     was_hit;
    logic [PROBE_W-1:0]       probes;
    logic                     probe_hit;
    logic                     req_fire;
    req_t                     req_q;
    logic [DATA_W-1:0]        fill_q;
    logic [WAYS*LINE_W-1:0]   lines_flat;
    logic [LINE_W-1:0]        sel_flat;
    line_t                    sel_l;
    line_t                    base_l;
    line_t                    upd_l;
    logic [WAYS*ADDR_W-1:0]   tag_vec;

    assign req_ready = (state == PS_IDLE);
    assign req_fire  = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            fill_q <= '0;
        end else begin
            if (req_fire) begin
                req_q <= '{tag: req_addr, wr: req_wr, wdata: req_wdata};
            end
            if (state == PS_REFILL_WAIT && refill_valid) begin
                fill_q <= refill_data;
            end
        end
    end

    seqprobe_fsm #(
        .WAYS    (WAYS),
        .IDX_W   (IDX_W),
        .PROBE_W (PROBE_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_fire     (req_fire),
        .probe_hit    (probe_hit),
        .refill_valid (refill_valid),
        .state        (state),
        .idx          (idx),
        .was_hit      (was_hit),
        .probes       (probes)
    );

    seqprobe_match #(
        .WAYS   (WAYS),
        .TAG_W  (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_match (
        .lines_flat (lines_flat),
        .idx        (idx),
        .tag        (req_q.tag),
        .hit        (probe_hit),
        .sel_line   (sel_flat)
    );

    assign sel_l = line_t'(sel_flat);

    // Line written to way 1: the promoted line on a hit, the refill on a miss.
    always_comb begin
        if (was_hit) begin
            base_l = sel_l;
        end else begin
            base_l.valid = 1'b1;
            base_l.dirty = 1'b0;
            base_l.tag   = req_q.tag;
            base_l.data  = fill_q;
        end
        upd_l = base_l;
        if (req_q.wr) begin
            upd_l.data  = req_q.wdata;
            upd_l.dirty = 1'b1;
        end
    end

    seqprobe_lines #(
        .WAYS   (WAYS),
        .TAG_W  (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_lines (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (state == PS_SHIFT),
        .depth      (idx),
        .new_line   (upd_l),
        .lines_flat (lines_flat)
    );

    assign rsp_valid        = (state == PS_SHIFT);
    assign rsp_hit          = was_hit;
    assign rsp_probes       = probes;
    assign rsp_data         = upd_l.data;
    assign refill_req_valid = (state == PS_REFILL_WAIT);
    assign refill_req_addr  = req_q.tag;
    // On a miss the probe index rests on the last way, which is the victim.
    assign evict_valid      = (state == PS_SHIFT) && !was_hit && sel_l.valid;
    assign evict_addr       = sel_l.tag;
    assign evict_data       = sel_l.data;
    assign evict_dirty      = sel_l.dirty;

    for (genvar w = 0; w < WAYS; w++) begin : g_tags
        assign tag_vec[w*ADDR_W +: ADDR_W] = lines_flat[w*LINE_W + DATA_W +: ADDR_W];
    end

    AST_MISS_PROBES_ALL: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_probes == PROBE_W'(WAYS)))
        else $error("miss reported before all ways probed"); // R3

    AST_REFILL_HELD: assert property (@(posedge clk) disable iff (rst)
        (refill_req_valid && !refill_valid) |=> (refill_req_valid && $stable(refill_req_addr)))
        else $error("refill request dropped or changed"); // R3

    AST_EVICT_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> (rsp_valid && !rsp_hit))
        else $error("eviction outside a miss response"); // R7

    AST_MRU_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (lines_flat[LINE_W-1] && tag_vec[ADDR_W-1:0] == $past(req_q.tag)))
        else $error("accessed line not in way 1"); // R4

    AST_HEAD_HIT_KEEPS_ORDER: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && rsp_probes == PROBE_W'(1)) |=> $stable(tag_vec))
        else $error("hit in way 1 changed line order"); // R5

    AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready))
        else $error("response not a single pulse"); // R10

endmodule

// File: tb/test_seqprobe_set.sv
module test_seqprobe_set;

    localparam int WAYS    = 4;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int PROBE_W = $clog2(WAYS + 1);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic               req_wr = 1'b0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic               rsp_valid;
    logic               rsp_hit;
    logic [PROBE_W-1:0] rsp_probes;
    logic [DATA_W-1:0]  rsp_data;
    logic               refill_req_valid;
    logic [ADDR_W-1:0]  refill_req_addr;
    logic               refill_valid = 1'b0;
    logic [DATA_W-1:0]  refill_data = '0;
    logic               evict_valid;
    logic [ADDR_W-1:0]  evict_addr;
    logic [DATA_W-1:0]  evict_data;
    logic               evict_dirty;

    always #10 clk = ~clk;

    seqprobe_set #(.WAYS(WAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seqprobe_set (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wr(req_wr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_probes(rsp_probes), .rsp_data(rsp_data),
        .refill_req_valid(refill_req_valid), .refill_req_addr(refill_req_addr),
        .refill_valid(refill_valid), .refill_data(refill_data),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .evict_data(evict_data), .evict_dirty(evict_dirty)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int last_probes = 0;
    bit last_hit = 1'b0;

    logic              m_val   [WAYS];
    logic              m_dirty [WAYS];
    logic [ADDR_W-1:0] m_tag   [WAYS];
    logic [DATA_W-1:0] m_data  [WAYS];

    function automatic logic [DATA_W-1:0] fill_value(logic [ADDR_W-1:0] a);
        return (DATA_W'(a) * DATA_W'(32'h9E37_79B9)) ^ DATA_W'(32'h5A3C_96E1);
    endfunction

    function automatic int find_way(logic [ADDR_W-1:0] a);
        for (int i = 0; i < WAYS; i++) begin
            if (m_val[i] && m_tag[i] == a) return i;
        end
        return -1;
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input bit wr, input logic [DATA_W-1:0] wd);
        int k = find_way(a);
        bit exp_hit = (k >= 0);
        int exp_probes = exp_hit ? k + 1 : WAYS;
        bit exp_ev = !exp_hit && m_val[WAYS-1];
        logic [ADDR_W-1:0] ev_tag = m_tag[WAYS-1];
        logic [DATA_W-1:0] ev_data = m_data[WAYS-1];
        logic ev_dirty = m_dirty[WAYS-1];
        logic [DATA_W-1:0] exp_data = wr ? wd : (exp_hit ? m_data[k] : fill_value(a));
        string ord_req = exp_hit ? ((k == 0) ? "R5" : "R4") : "R6";
        string dat_req = wr ? "R8" : "R9";
        int edges = 0;
        int guard = 0;
        bit refilled = 1'b0;
        bit done = 1'b0;
        int depth;
        logic              n_val, n_dirty;
        logic [ADDR_W-1:0] n_tag;
        logic [DATA_W-1:0] n_data;

        @(negedge clk);
        while (!req_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1; req_addr = a; req_wr = wr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done) begin
            if (rsp_valid) begin
                check_eq(ord_req, "rsp_hit", rsp_hit, exp_hit);
                check_eq(ord_req, "rsp_probes", rsp_probes, exp_probes);
                if (exp_hit) check_eq("R2", "hit latency edges", edges, exp_probes);
                check_eq(dat_req, "rsp_data", rsp_data, exp_data);
                check_eq("R10", "ready in response cycle", req_ready, 0);
                check_eq("R7", "evict_valid", evict_valid, exp_ev);
                if (exp_ev) begin
                    check_eq("R7", "evict_addr", evict_addr, ev_tag);
                    check_eq("R7", "evict_data", evict_data, ev_data);
                    check_eq("R7", "evict_dirty", evict_dirty, ev_dirty);
                end
                last_probes = int'(rsp_probes);
                last_hit = rsp_hit;
                done = 1'b1;
            end else begin
                check_eq("R10", "ready while busy", req_ready, 0);
                check_eq("R7", "evict outside response", evict_valid, 0);
                if (refill_req_valid && !refilled) begin
                    check_eq("R3", "refill on hit", exp_hit, 0);
                    check_eq("R3", "refill timing edges", edges, WAYS);
                    check_eq("R3", "refill_req_addr", refill_req_addr, a);
                    repeat ($urandom_range(0, 3)) begin
                        @(posedge clk);
                        @(negedge clk);
                        edges++;
                    end
                    check_eq("R3", "refill held", {refill_req_valid, refill_req_addr}, {1'b1, a});
                    refill_valid = 1'b1;
                    refill_data = fill_value(a);
                    refilled = 1'b1;
                end
                @(posedge clk);
                @(negedge clk);
                refill_valid = 1'b0;
                edges++;
                guard++;
                if (guard > 64) begin
                    check_eq("R10", "response timeout", 0, 1);
                    done = 1'b1;
                end
            end
        end

        // Reference reordering
        if (exp_hit) begin
            n_val = 1'b1; n_tag = a; n_dirty = m_dirty[k] | wr; n_data = wr ? wd : m_data[k];
            depth = k;
        end else begin
            n_val = 1'b1; n_tag = a; n_dirty = wr; n_data = wr ? wd : fill_value(a);
            depth = WAYS - 1;
        end
        for (int i = depth; i > 0; i--) begin
            m_val[i] = m_val[i-1]; m_dirty[i] = m_dirty[i-1];
            m_tag[i] = m_tag[i-1]; m_data[i] = m_data[i-1];
        end
        m_val[0] = n_val; m_dirty[0] = n_dirty; m_tag[0] = n_tag; m_data[0] = n_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check_eq("R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < WAYS; i++) begin
            m_val[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "rsp_valid in reset", rsp_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "req_ready after reset", req_ready, 1);
        check_eq("R1", "rsp_valid after reset", rsp_valid, 0);
        check_eq("R1", "refill_req_valid after reset", refill_req_valid, 0);
        check_eq("R1", "evict_valid after reset", evict_valid, 0);

        // Directed: fill, head hit, deep promotion, clean and dirty eviction
        access(16'h0A00, 1'b0, '0);
        check_eq("R1", "first access misses", last_hit, 0);
        access(16'h0B00, 1'b0, '0);
        access(16'h0C00, 1'b0, '0);
        access(16'h0D00, 1'b0, '0);
        access(16'h0D00, 1'b0, '0);
        check_eq("R5", "head hit probes", last_probes, 1);
        access(16'h0C00, 1'b0, '0);
        check_eq("R4", "second-way hit probes", last_probes, 2);
        access(16'h0A00, 1'b0, '0);
        check_eq("R4", "last-way hit probes", last_probes, 4);
        access(16'h0E00, 1'b1, 32'hDEAD_BEEF);
        access(16'h0E00, 1'b0, '0);
        check_eq("R11", "repeat after miss hits way 1", last_probes, 1);
        access(16'h0D00, 1'b1, 32'h1234_5678);
        access(16'h0F00, 1'b0, '0);
        access(16'h0F10, 1'b0, '0);
        access(16'h0F20, 1'b0, '0);
        access(16'h0F30, 1'b0, '0);
        access(16'h0F40, 1'b0, '0);

        // Random mix over a pool slightly larger than the set
        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] a = ADDR_W'(16'h0100 + $urandom_range(0, 6));
            bit wr = ($urandom_range(0, 9) < 3);
            access(a, wr, $urandom);
        end
        finish_run();
    end

endmodule